// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Control

This block steers operands and stalls for an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. Each cycle the decode stage presents its source register indices, with a flag per source saying whether it is read, and the destination, write enable and load flag of the instruction it holds. The block keeps its own record of the destinations of the three older instructions in execute, memory and writeback. For each source it returns a select that tells the decode-side operand mux to take the execute result, the memory-stage value, or the register file.

Results from the ALU are forwarded with no lost cycle. A load delivers its data only at the end of the memory stage. An instruction that reads a load result in the very next slot is therefore held in decode for one cycle, and an empty slot enters execute behind the load. The register file writes through, so a value being written back in the current cycle can be read by decode in that cycle, and the writeback stage needs no forwarding path of its own.

The record of each stage is a small state machine holding its occupant class. The states are EMPTY (a bubble, or an instruction that writes nothing), ALU (writes a computed result) and LOAD (writes memory data). There are two transitions into execute. On an issue, execute takes the class of the decode instruction. On a bubble, caused by a stall or an empty decode slot, execute goes to EMPTY. The memory and writeback stages copy the class of the stage before them on every clock.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: After reset all three stage records are EMPTY. Until an instruction has issued, `stall` is 0, `wb_wen` is 0 and every `fwd_sel` is 0 (register file).
- R2: A source whose index matches an ALU-class instruction in execute gets `fwd_sel` = 1 (execute result), and `stall` stays 0.
- R3: A source that matches no execute occupant but matches a memory-stage occupant of either class gets `fwd_sel` = 2 (memory-stage value).
- R4: When the execute and memory occupants both write the source register, the execute one is chosen (`fwd_sel` = 1).
- R5: A source that matches a LOAD-class instruction in execute raises `stall` and gets `fwd_sel` = 0 in that cycle. When the same decode instruction is presented again in the next cycle, `stall` is 0 and the source gets `fwd_sel` = 2.
- R6: A stall cycle issues nothing. The slot behind the load reaches writeback as a bubble (`wb_wen` = 0). The held instruction issues one cycle later and reaches writeback in order.
- R7: Source index 0 always gets `fwd_sel` = 0 and never causes a stall, even when an older instruction writes register 0.
- R8: An older instruction with its write enable cleared is ignored for both forwarding and stalls, even when its load flag is set.
- R9: An instruction decoded in cycle c appears on `wb_rd` with `wb_wen` = 1 in cycle c+3. A source that matches only that writeback occupant gets `fwd_sel` = 0.
- R10: A source whose read flag is 0 gets `fwd_sel` = 0 and never causes a stall.
- R11: When `dec_valid` is 0, `stall` is 0 and every `fwd_sel` is 0.
- R12: Each source is resolved on its own. One source may forward from execute while the other forwards from memory, and a load hit on either source raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_src_idx | input | NSRC x AW | Source register index for each operand |
| dec_src_use | input | NSRC | Operand is actually read |
| dec_rd | input | AW | Destination register of the decode instruction |
| dec_wen | input | 1 | Decode instruction writes a register |
| dec_load | input | 1 | Decode instruction is a load |
| stall | output | 1 | Hold PC and the fetch/decode register; the execute stage receives a bubble |
| fwd_sel | output | NSRC x 2 | Per operand: 0 register file, 1 execute result, 2 memory-stage value |
| wb_wen | output | 1 | Register file write enable for the writeback stage |
| wb_rd | output | AW | Register file write index for the writeback stage |

## Verification
A corrupted occupant class or destination in the execute record shows up in the next decode cycle. It appears as a missing or spurious stall, or as a select of 1 where 2 or 0 was due. A fault in the memory record shows up one cycle later, as the wrong choice between the memory-stage value and the register file. Every stage record is also checked when it reaches `wb_wen` and `wb_rd`, exactly three cycles after decode. A lost or duplicated bubble therefore appears at the write port within three cycles.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Class of the instruction held in one pipeline stage record
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_ALU   = 2'd1,
        OCC_LOAD  = 2'd2
    } occ_e;

    // Operand source select presented to the decode-side mux
    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2
    } fwd_e;

endpackage

// File: rtl/hz_stage_pipe.sv
module hz_stage_pipe
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  occ_e          in_occ,
    input  logic [AW-1:0] in_rd,
    output occ_e          x_occ,
    output logic [AW-1:0] x_rd,
    output occ_e          m_occ,
    output logic [AW-1:0] m_rd,
    output occ_e          w_occ,
    output logic [AW-1:0] w_rd
);

    localparam int NSTG = 3;   // execute, memory, writeback

    occ_e          occ_q [NSTG];
    logic [AW-1:0] rd_q  [NSTG];
    occ_e          head_occ;
    logic [AW-1:0] head_rd;

    // Next state of the execute record: issue or bubble
    always_comb begin
        if (issue) begin
            head_occ = in_occ;
            head_rd  = in_rd;
        end else begin
            head_occ = OCC_EMPTY;
            head_rd  = '0;
        end
    end

    // State register for all stage records
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSTG; s++) begin
                occ_q[s] <= OCC_EMPTY;
                rd_q[s]  <= '0;
            end
        end else begin
            occ_q[0] <= head_occ;
            rd_q[0]  <= head_rd;
            for (int s = 1; s < NSTG; s++) begin
                occ_q[s] <= occ_q[s-1];
                rd_q[s]  <= rd_q[s-1];
            end
        end
    end

    assign x_occ = occ_q[0];
    assign x_rd  = rd_q[0];
    assign m_occ = occ_q[1];
    assign m_rd  = rd_q[1];
    assign w_occ = occ_q[2];
    assign w_rd  = rd_q[2];

endmodule

// File: rtl/hz_src_resolve.sv
module hz_src_resolve
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          active,
    input  logic [AW-1:0] idx,
    input  occ_e          x_occ,
    input  logic [AW-1:0] x_rd,
    input  occ_e          m_occ,
    input  logic [AW-1:0] m_rd,
    output fwd_e          sel,
    output logic          load_hit
);

    logic x_hit;
    logic m_hit;

    assign x_hit = active && (x_occ != OCC_EMPTY) && (x_rd == idx);
    assign m_hit = active && (m_occ != OCC_EMPTY) && (m_rd == idx);

    // Youngest producer wins; a load still in execute cannot be forwarded
    always_comb begin
        sel      = SEL_RF;
        load_hit = 1'b0;
        if (x_hit) begin
            unique case (x_occ)
                OCC_ALU:  sel      = SEL_EX;
                OCC_LOAD: load_hit = 1'b1;
                default:  sel      = SEL_RF;
            endcase
        end else if (m_hit) begin
            sel = SEL_MEM;
        end
    end

endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     dec_valid,
    input  logic [NSRC-1:0][AW-1:0]  dec_src_idx,
    input  logic [NSRC-1:0]          dec_src_use,
    input  logic [AW-1:0]            dec_rd,
    input  logic                     dec_wen,
    input  logic                     dec_load,
    output logic                     stall,
    output logic [NSRC-1:0][1:0]     fwd_sel,
    output logic                     wb_wen,
    output logic [AW-1:0]            wb_rd
);

    occ_e          dec_occ;
    occ_e          x_occ;
    occ_e          m_occ;
    occ_e          w_occ;
    logic [AW-1:0] x_rd;
    logic [AW-1:0] m_rd;
    logic [AW-1:0] w_rd;
    logic          issue;
    logic [NSRC-1:0] load_hit;
    fwd_e          sel_w [NSRC];

    // Class of the decode instruction
    always_comb begin
        unique case ({dec_wen, dec_load})
            2'b10:   dec_occ = OCC_ALU;
            2'b11:   dec_occ = OCC_LOAD;
            default: dec_occ = OCC_EMPTY;
        endcase
    end

    assign stall = |load_hit;
    assign issue = dec_valid & ~stall;

    hz_stage_pipe #(.AW(AW)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .issue  (issue),
        .in_occ (dec_occ),
        .in_rd  (dec_rd),
        .x_occ  (x_occ),
        .x_rd   (x_rd),
        .m_occ  (m_occ),
        .m_rd   (m_rd),
        .w_occ  (w_occ),
        .w_rd   (w_rd)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic src_active;
        assign src_active = dec_valid & dec_src_use[i] & (dec_src_idx[i] != '0);

        hz_src_resolve #(.AW(AW)) u_res (
            .active   (src_active),
            .idx      (dec_src_idx[i]),
            .x_occ    (x_occ),
            .x_rd     (x_rd),
            .m_occ    (m_occ),
            .m_rd     (m_rd),
            .sel      (sel_w[i]),
            .load_hit (load_hit[i])
        );

        assign fwd_sel[i] = sel_w[i];
    end

    assign wb_wen = (w_occ != OCC_EMPTY);
    assign wb_rd  = w_rd;

endmodule

// File: rtl/hz_chk.sv
module hz_chk
    import hz_pkg::*;
#(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    dec_valid,
    input logic [NSRC-1:0][AW-1:0] dec_src_idx,
    input logic [NSRC-1:0]         dec_src_use,
    input logic                    stall,
    input logic [NSRC-1:0][1:0]    fwd_sel,
    input logic                    wb_wen,
    input occ_e                    x_occ
);

    // R5
    r5_single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    // R6
    r6_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (x_occ == OCC_EMPTY));

    // R11
    r11_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall);

    // R9
    r9_wb_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_wen == $past(x_occ != OCC_EMPTY, 2));

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        // R7
        r7_zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dec_src_idx[i] == '0) |-> (fwd_sel[i] == 2'd0));

        // R10
        r10_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dec_src_use[i] |-> (fwd_sel[i] == 2'd0));

        // R3
        r3_sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_sel[i] != 2'd3);
    end

endmodule

bind pipe_hazard_ctl hz_chk #(.AW(AW), .NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .dec_src_idx (dec_src_idx),
    .dec_src_use (dec_src_use),
    .stall       (stall),
    .fwd_sel     (fwd_sel),
    .wb_wen      (wb_wen),
    .x_occ       (x_occ)
);

// File: tb/sim_pipe_hazard_ctl.sv
`timescale 1ns/1ps
module sim_pipe_hazard_ctl;

    localparam int AW   = 5;
    localparam int NSRC = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    dec_valid = 1'b0;
    logic [NSRC-1:0][AW-1:0] dec_src_idx = '0;
    logic [NSRC-1:0]         dec_src_use = '0;
    logic [AW-1:0]           dec_rd = '0;
    logic                    dec_wen = 1'b0;
    logic                    dec_load = 1'b0;
    logic                    stall;
    logic [NSRC-1:0][1:0]    fwd_sel;
    logic                    wb_wen;
    logic [AW-1:0]           wb_rd;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pipe_hazard_ctl #(.AW(AW), .NSRC(NSRC)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_valid   (dec_valid),
        .dec_src_idx (dec_src_idx),
        .dec_src_use (dec_src_use),
        .dec_rd      (dec_rd),
        .dec_wen     (dec_wen),
        .dec_load    (dec_load),
        .stall       (stall),
        .fwd_sel     (fwd_sel),
        .wb_wen      (wb_wen),
        .wb_rd       (wb_rd)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Present one decode slot after the falling edge; outputs are read 1 ns later
    task automatic slot(input logic v, input int s1, input logic u1,
                        input int s2, input logic u2,
                        input int rd, input logic we, input logic ld);
        @(negedge clk);
        dec_valid      = v;
        dec_src_idx[0] = AW'(s1);
        dec_src_use[0] = u1;
        dec_src_idx[1] = AW'(s2);
        dec_src_use[1] = u2;
        dec_rd         = AW'(rd);
        dec_wen        = we;
        dec_load       = ld;
        #1;
    endtask

    task automatic idle();
        slot(1'b0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic flush();
        repeat (3) idle();
    endtask

    task automatic t_reset();
        slot(1'b1, 5, 1'b1, 6, 1'b1, 0, 1'b0, 1'b0);
        check("R1 stall", int'(stall), 0);
        check("R1 sel0", int'(fwd_sel[0]), 0);
        check("R1 sel1", int'(fwd_sel[1]), 0);
        check("R1 wb_wen", int'(wb_wen), 0);
    endtask

    task automatic t_ex_fwd();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 5, 1'b1, 1'b0);
        slot(1'b1, 5, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0);
        check("R2 sel0", int'(fwd_sel[0]), 1);
        check("R2 stall", int'(stall), 0);
    endtask

    task automatic t_mem_fwd();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 6, 1'b1, 1'b0);
        idle();
        slot(1'b1, 0, 1'b0, 6, 1'b1, 0, 1'b0, 1'b0);
        check("R3 sel1", int'(fwd_sel[1]), 2);
        check("R3 stall", int'(stall), 0);
    endtask

    task automatic t_priority();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 7, 1'b1, 1'b0);
        slot(1'b1, 0, 1'b0, 0, 1'b0, 7, 1'b1, 1'b0);
        slot(1'b1, 7, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0);
        check("R4 sel0", int'(fwd_sel[0]), 1);
    endtask

    task automatic t_load_use();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 8, 1'b1, 1'b1);
        slot(1'b1, 8, 1'b1, 0, 1'b0, 9, 1'b1, 1'b0);
        check("R5 stall", int'(stall), 1);
        check("R5 sel0 held", int'(fwd_sel[0]), 0);
        slot(1'b1, 8, 1'b1, 0, 1'b0, 9, 1'b1, 1'b0);
        check("R5 stall released", int'(stall), 0);
        check("R5 sel0 mem", int'(fwd_sel[0]), 2);
        idle();
        check("R6 load wb_wen", int'(wb_wen), 1);
        check("R6 load wb_rd", int'(wb_rd), 8);
        idle();
        check("R6 bubble wb_wen", int'(wb_wen), 0);
        idle();
        check("R6 held wb_wen", int'(wb_wen), 1);
        check("R6 held wb_rd", int'(wb_rd), 9);
    endtask

    task automatic t_x0();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0);
        slot(1'b1, 0, 1'b1, 0, 1'b1, 0, 1'b1, 1'b1);
        check("R7 sel0", int'(fwd_sel[0]), 0);
        check("R7 sel1", int'(fwd_sel[1]), 0);
        slot(1'b1, 0, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0);
        check("R7 no stall on x0 load", int'(stall), 0);
    endtask

    task automatic t_wen_off();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 10, 1'b0, 1'b1);
        slot(1'b1, 10, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0);
        check("R8 stall", int'(stall), 0);
        check("R8 sel0", int'(fwd_sel[0]), 0);
        slot(1'b1, 0, 1'b0, 10, 1'b1, 0, 1'b0, 1'b0);
        check("R8 sel1 mem", int'(fwd_sel[1]), 0);
    endtask

    task automatic t_wb_only();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 11, 1'b1, 1'b0);
        idle();
        idle();
        slot(1'b1, 11, 1'b1, 0, 1'b0, 0, 1'b0, 1'b0);
        check("R9 sel0", int'(fwd_sel[0]), 0);
        check("R9 wb_wen", int'(wb_wen), 1);
        check("R9 wb_rd", int'(wb_rd), 11);
    endtask

    task automatic t_unused();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 12, 1'b1, 1'b1);
        slot(1'b1, 12, 1'b0, 12, 1'b0, 0, 1'b0, 1'b0);
        check("R10 stall", int'(stall), 0);
        check("R10 sel0", int'(fwd_sel[0]), 0);
        check("R10 sel1", int'(fwd_sel[1]), 0);
    endtask

    task automatic t_invalid();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 13, 1'b1, 1'b1);
        slot(1'b0, 13, 1'b1, 13, 1'b1, 0, 1'b0, 1'b0);
        check("R11 stall", int'(stall), 0);
        check("R11 sel0", int'(fwd_sel[0]), 0);
        check("R11 sel1", int'(fwd_sel[1]), 0);
    endtask

    task automatic t_indep();
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 14, 1'b1, 1'b0);
        slot(1'b1, 0, 1'b0, 0, 1'b0, 15, 1'b1, 1'b0);
        slot(1'b1, 15, 1'b1, 14, 1'b1, 0, 1'b0, 1'b0);
        check("R12 sel0 ex", int'(fwd_sel[0]), 1);
        check("R12 sel1 mem", int'(fwd_sel[1]), 2);
        check("R12 stall", int'(stall), 0);
        flush();
        slot(1'b1, 0, 1'b0, 0, 1'b0, 16, 1'b1, 1'b1);
        slot(1'b1, 3, 1'b1, 16, 1'b1, 0, 1'b0, 1'b0);
        check("R12 stall on second source", int'(stall), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ex_fwd();
        t_mem_fwd();
        t_priority();
        t_load_use();
        t_x0();
        t_wen_off();
        t_wb_only();
        t_unused();
        t_invalid();
        t_indep();
        flush();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule